// File: doc/BRIEF.md
# Sync Polarity and Presence Detector

This block watches a separate horizontal and a separate vertical sync input, each of which arrives asynchronously to a fast system clock. Every sync input is brought into the clock domain through a two-flop synchronizer. At a fixed interval of clock cycles the synchronized level is sampled. When a window of samples closes, the polarity of the channel is decided from how many of those samples were high. The short pulse of a sync signal is its active level, so a signal that is mostly low has positive polarity. Each channel also counts its own transitions inside a long timeout window, which gives a presence flag. The flag tells software whether that sync input is toggling at all.

The same inputs are passed straight to the sync output pins with no register on the way. The only change on that path is an optional inversion, so that the pin always carries the polarity selected by a control bit. Each output has an active-low enable. While the enable is high, the pin shows a general-purpose value from elsewhere in the chip instead of the sync signal.

Top module: `syncPolarityMonitor`

## Requirements
- R1: After reset is released, `hPolStat`, `vPolStat`, `hPresent` and `vPresent` all read 0.
- R2: Each sync input passes through two synchronizer flops before any status logic uses it. An input transition therefore affects a presence bit no earlier than the third rising clock edge after the change.
- R3: A sample is taken every `SAMPLE_DIV` clock cycles, and a polarity window spans `WINDOW_SAMPLES` samples. When a window closes, the polarity bit becomes 1 (positive) if fewer than half of its samples were high, and 0 (negative) otherwise. A window with exactly half high gives 0, a constantly high input gives 0, and a constantly low input gives 1.
- R4: A polarity status bit changes only on the cycle that closes a polarity window. Between those cycles it holds its value.
- R5: An edge is a change of the synchronized level in either direction. The presence bit is set on the clock edge after the second edge seen within the current presence window.
- R6: A presence window lasts `TIMEOUT_CYCLES` cycles. When it closes, the presence bit is reloaded with (edges in the closing window >= 2), and an edge on the closing cycle counts toward it. A window with zero edges or a single edge therefore clears the bit.
- R7: While the enable bit is 0, the sync pin equals `syncIn XOR (polStat XOR polSel)`, where a select value of 1 requests positive polarity and 0 requests negative polarity. This path is combinational, with no clock delay.
- R8: While the enable bit is 1, the sync pin equals the general-purpose value, and the sync input has no effect on the pin.
- R9: The horizontal and vertical channels are independent. Activity on one channel changes no status bit of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSyncIn | input | 1 | Horizontal sync input, asynchronous |
| vSyncIn | input | 1 | Vertical sync input, asynchronous |
| hPolSel | input | 1 | Requested horizontal output polarity (1 positive) |
| vPolSel | input | 1 | Requested vertical output polarity (1 positive) |
| hOutEnN | input | 1 | Horizontal output enable, active low |
| vOutEnN | input | 1 | Vertical output enable, active low |
| hGpioOut | input | 1 | Value driven on the horizontal pin while disabled |
| vGpioOut | input | 1 | Value driven on the vertical pin while disabled |
| hSyncPin | output | 1 | Horizontal pin value |
| vSyncPin | output | 1 | Vertical pin value |
| hPolStat | output | 1 | Detected horizontal polarity (1 positive) |
| vPolStat | output | 1 | Detected vertical polarity (1 positive) |
| hPresent | output | 1 | Horizontal sync activity present |
| vPresent | output | 1 | Vertical sync activity present |

## Verification
The close of a polarity window and the close of a presence window can fall on the same clock cycle. When that happens, both status bits of a channel are rewritten in one cycle from two separate counters. The bench sets the presence window to an exact multiple of the polarity window, so the two closes coincide once in every presence window. It keeps sync patterns running across many such coincidences and then checks that each polarity bit matches the duty cycle and each presence bit matches the activity. Separately, edges placed at known cycle offsets let the bench tell an immediate set from a set that happens only when a window closes.

// File: rtl/syncMonPkg.sv
`timescale 1ns/1ps
package syncMonPkg;
  localparam int NUM_CH = 2;
  localparam int CH_H   = 0;
  localparam int CH_V   = 1;

  // strobes from the timing control to the per-channel datapath
  typedef struct packed {
    logic sampleTick;   // take one level sample this cycle
    logic windowEnd;    // last sample of a polarity window
    logic timeoutEnd;   // last cycle of a presence window
  } monStrobe_t;
endpackage

// File: rtl/syncMonCtrl.sv
`timescale 1ns/1ps
module syncMonCtrl
  import syncMonPkg::*;
#(
  parameter int SAMPLE_DIV     = 16,
  parameter int WINDOW_SAMPLES = 64,
  parameter int TIMEOUT_CYCLES = 2600000
) (
  input  logic       clk,
  input  logic       rstN,
  output monStrobe_t strobe
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int SMP_W = (WINDOW_SAMPLES > 1) ? $clog2(WINDOW_SAMPLES) : 1;
  localparam int TO_W  = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(WINDOW_SAMPLES - 1);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYCLES - 1);

  logic [DIV_W-1:0] divCnt;
  logic [SMP_W-1:0] smpCnt;
  logic [TO_W-1:0]  toCnt;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      smpCnt <= '0;
      toCnt  <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) smpCnt <= (smpCnt == SMP_LAST) ? '0 : smpCnt + 1'b1;
      toCnt <= (toCnt == TO_LAST) ? '0 : toCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.sampleTick = tick;
    strobe.windowEnd  = tick && (smpCnt == SMP_LAST);
    strobe.timeoutEnd = (toCnt == TO_LAST);
  end
endmodule

// File: rtl/syncMonChannel.sv
`timescale 1ns/1ps
module syncMonChannel
  import syncMonPkg::*;
#(
  parameter int WINDOW_SAMPLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  monStrobe_t strobe,
  input  logic       syncIn,
  input  logic       polSel,
  input  logic       outEnN,
  input  logic       gpioOut,
  output logic       syncPin,
  output logic       polStat,
  output logic       present
);
  localparam int CNT_W = $clog2(WINDOW_SAMPLES + 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WINDOW_SAMPLES / 2);

  logic [1:0]       syncFf;
  logic             syncPrev;
  logic             level;
  logic             edgeSeen;
  logic [CNT_W-1:0] highCnt;
  logic [CNT_W-1:0] highNext;
  logic [1:0]       edgeCnt;
  logic [1:0]       edgeNext;

  assign level    = syncFf[1];
  assign edgeSeen = level ^ syncPrev;
  assign highNext = highCnt + CNT_W'(level);
  // saturating count of edges: 0, 1, 2 or more
  assign edgeNext = (edgeSeen && edgeCnt != 2'd2) ? edgeCnt + 2'd1 : edgeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncFf   <= '0;
      syncPrev <= 1'b0;
      highCnt  <= '0;
      polStat  <= 1'b0;
      edgeCnt  <= '0;
      present  <= 1'b0;
    end else begin
      syncFf   <= {syncFf[0], syncIn};
      syncPrev <= level;
      if (strobe.sampleTick) begin
        if (strobe.windowEnd) begin
          polStat <= (highNext < HALF);
          highCnt <= '0;
        end else begin
          highCnt <= highNext;
        end
      end
      if (strobe.timeoutEnd) begin
        present <= (edgeNext == 2'd2);
        edgeCnt <= '0;
      end else begin
        edgeCnt <= edgeNext;
        if (edgeNext == 2'd2) present <= 1'b1;
      end
    end
  end

  // zero-delay pin path: invert when detected and requested polarity differ
  assign syncPin = outEnN ? gpioOut : (syncIn ^ (polStat ^ polSel));
endmodule

// File: rtl/syncMonDatapath.sv
`timescale 1ns/1ps
module syncMonDatapath
  import syncMonPkg::*;
#(
  parameter int WINDOW_SAMPLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strobe,
  input  logic [NUM_CH-1:0] syncIn,
  input  logic [NUM_CH-1:0] polSel,
  input  logic [NUM_CH-1:0] outEnN,
  input  logic [NUM_CH-1:0] gpioOut,
  output logic [NUM_CH-1:0] syncPin,
  output logic [NUM_CH-1:0] polStat,
  output logic [NUM_CH-1:0] present
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    syncMonChannel #(.WINDOW_SAMPLES(WINDOW_SAMPLES)) i_chan (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .syncIn  (syncIn[ch]),
      .polSel  (polSel[ch]),
      .outEnN  (outEnN[ch]),
      .gpioOut (gpioOut[ch]),
      .syncPin (syncPin[ch]),
      .polStat (polStat[ch]),
      .present (present[ch])
    );
  end
endmodule

// File: rtl/syncPolarityMonitor.sv
`timescale 1ns/1ps
module syncPolarityMonitor
  import syncMonPkg::*;
#(
  parameter int SAMPLE_DIV     = 16,
  parameter int WINDOW_SAMPLES = 64,
  parameter int TIMEOUT_CYCLES = 2600000
) (
  input  logic clk,
  input  logic rstN,
  input  logic hSyncIn,
  input  logic vSyncIn,
  input  logic hPolSel,
  input  logic vPolSel,
  input  logic hOutEnN,
  input  logic vOutEnN,
  input  logic hGpioOut,
  input  logic vGpioOut,
  output logic hSyncPin,
  output logic vSyncPin,
  output logic hPolStat,
  output logic vPolStat,
  output logic hPresent,
  output logic vPresent
);
  monStrobe_t        strobe;
  logic [NUM_CH-1:0] pinVec;
  logic [NUM_CH-1:0] polVec;
  logic [NUM_CH-1:0] presVec;

  syncMonCtrl #(
    .SAMPLE_DIV     (SAMPLE_DIV),
    .WINDOW_SAMPLES (WINDOW_SAMPLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  syncMonDatapath #(.WINDOW_SAMPLES(WINDOW_SAMPLES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .syncIn  ({vSyncIn, hSyncIn}),
    .polSel  ({vPolSel, hPolSel}),
    .outEnN  ({vOutEnN, hOutEnN}),
    .gpioOut ({vGpioOut, hGpioOut}),
    .syncPin (pinVec),
    .polStat (polVec),
    .present (presVec)
  );

  assign hSyncPin = pinVec[CH_H];
  assign vSyncPin = pinVec[CH_V];
  assign hPolStat = polVec[CH_H];
  assign vPolStat = polVec[CH_V];
  assign hPresent = presVec[CH_H];
  assign vPresent = presVec[CH_V];
endmodule

// File: rtl/syncMonChecker.sv
`timescale 1ns/1ps
module syncMonChecker
  import syncMonPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input monStrobe_t strobe,
  input logic       hSyncIn,
  input logic       vSyncIn,
  input logic       hPolSel,
  input logic       vPolSel,
  input logic       hOutEnN,
  input logic       vOutEnN,
  input logic       hSyncPin,
  input logic       vSyncPin,
  input logic       hPolStat,
  input logic       vPolStat,
  input logic       hPresent,
  input logic       vPresent
);
  a_r3_window_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    strobe.windowEnd |-> strobe.sampleTick);

  a_r4_hpol_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.windowEnd |=> $stable(hPolStat));

  a_r4_vpol_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.windowEnd |=> $stable(vPolStat));

  a_r6_hpres_fall_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.timeoutEnd |=> !$fell(hPresent));

  a_r6_vpres_fall_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.timeoutEnd |=> !$fell(vPresent));

  a_r7_hpass_when_match: assert property (@(posedge clk) disable iff (!rstN)
    (!hOutEnN && (hPolSel == hPolStat)) |-> (hSyncPin == hSyncIn));

  a_r7_vpass_when_match: assert property (@(posedge clk) disable iff (!rstN)
    (!vOutEnN && (vPolSel == vPolStat)) |-> (vSyncPin == vSyncIn));
endmodule

bind syncPolarityMonitor syncMonChecker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .hSyncIn  (hSyncIn),
  .vSyncIn  (vSyncIn),
  .hPolSel  (hPolSel),
  .vPolSel  (vPolSel),
  .hOutEnN  (hOutEnN),
  .vOutEnN  (vOutEnN),
  .hSyncPin (hSyncPin),
  .vSyncPin (vSyncPin),
  .hPolStat (hPolStat),
  .vPolStat (vPolStat),
  .hPresent (hPresent),
  .vPresent (vPresent)
);

// File: tb/test_syncPolarityMonitor.sv
`timescale 1ns/1ps
module test_syncPolarityMonitor;
  localparam int SDIV = 2;
  localparam int NWIN = 64;
  localparam int TOUT = 1024;
  localparam int WCYC = SDIV * NWIN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSyncIn, vSyncIn, hPolSel, vPolSel, hOutEnN, vOutEnN, hGpioOut, vGpioOut;
  logic hSyncPin, vSyncPin, hPolStat, vPolStat, hPresent, vPresent;

  always #2.5 clk = ~clk;

  syncPolarityMonitor #(
    .SAMPLE_DIV(SDIV), .WINDOW_SAMPLES(NWIN), .TIMEOUT_CYCLES(TOUT)
  ) i_syncPolarityMonitor (
    .clk(clk), .rstN(rstN),
    .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .hPolSel(hPolSel), .vPolSel(vPolSel),
    .hOutEnN(hOutEnN), .vOutEnN(vOutEnN),
    .hGpioOut(hGpioOut), .vGpioOut(vGpioOut),
    .hSyncPin(hSyncPin), .vSyncPin(vSyncPin),
    .hPolStat(hPolStat), .vPolStat(vPolStat),
    .hPresent(hPresent), .vPresent(vPresent)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int per [2];
  int hiLen [2];
  int ph [2];
  bit run [2];
  logic cst [2];
  logic expPol [2];

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // pattern generator: the only driver of the sync inputs, updates at negedge
  initial begin
    hSyncIn = 1'b0;
    vSyncIn = 1'b0;
    for (int c = 0; c < 2; c++) begin
      run[c] = 0; cst[c] = 1'b0; per[c] = 2; hiLen[c] = 1; ph[c] = 0;
    end
    forever begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        logic lv;
        if (run[c]) begin
          lv = (ph[c] < hiLen[c]);
          ph[c] = (ph[c] + 1) % per[c];
        end else begin
          lv = cst[c];
        end
        if (c == 0) hSyncIn = lv; else vSyncIn = lv;
      end
    end
  end

  function automatic logic polOf(int p, int h);
    return (2 * h < p) ? 1'b1 : 1'b0;  // short high pulse means positive
  endfunction

  function automatic logic pinOf(logic sIn, logic pol, logic sel, logic enN, logic gp);
    return enN ? gp : (sIn ^ (pol ^ sel));
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitPhase(int m, int v);
    do begin
      @(posedge clk);
      #1;
    end while ((cyc % m) != v);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic setPattern(int c, int p, int h);
    per[c] = p; hiLen[c] = h; ph[c] = 0; run[c] = 1;
    expPol[c] = polOf(p, h);
  endtask

  task automatic pinChecks(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #0.5;
      hPolSel = 1'($urandom); vPolSel = 1'($urandom);
      hOutEnN = 1'($urandom); vOutEnN = 1'($urandom);
      hGpioOut = 1'($urandom); vGpioOut = 1'($urandom);
      #0.5;
      check({tag, " h pin"}, hSyncPin, pinOf(hSyncIn, expPol[0], hPolSel, hOutEnN, hGpioOut));
      check({tag, " v pin"}, vSyncPin, pinOf(vSyncIn, expPol[1], vPolSel, vOutEnN, vGpioOut));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f3a));
    hPolSel = 1'b1; vPolSel = 1'b1; hOutEnN = 1'b1; vOutEnN = 1'b1;
    hGpioOut = 1'b0; vGpioOut = 1'b0;
    expPol[0] = 1'b0; expPol[1] = 1'b0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    check("R1 hPolStat", hPolStat, 1'b0);
    check("R1 vPolStat", vPolStat, 1'b0);
    check("R1 hPresent", hPresent, 1'b0);
    check("R1 vPresent", vPresent, 1'b0);

    // R2/R5: one pulse on H, two edges inside one presence window
    waitPhase(TOUT, 200);
    cst[0] = 1'b1;
    waitCyc(3);
    check("R2 first edge only, hPresent", hPresent, 1'b0);
    waitCyc(2);
    cst[0] = 1'b0;
    waitCyc(2);
    check("R2 second edge not yet through synchronizer", hPresent, 1'b0);
    waitCyc(1);
    check("R5 set after second edge", hPresent, 1'b1);
    check("R9 vPresent untouched", vPresent, 1'b0);
    // R6: the closing window held 2 edges, so the bit survives it
    waitPhase(TOUT, 50);
    check("R6 kept after window with two edges", hPresent, 1'b1);
    check("R3 constant low vertical is positive", vPolStat, 1'b1);
    // R6: next window has no edges and clears it
    waitPhase(TOUT, 50);
    check("R6 cleared after silent window", hPresent, 1'b0);
    // R6: a single edge in a window is not enough
    waitPhase(TOUT, 300);
    cst[0] = 1'b1;
    waitCyc(10);
    check("R6 single edge no set", hPresent, 1'b0);
    waitPhase(TOUT, 50);
    check("R6 single edge window stays clear", hPresent, 1'b0);
    check("R3 constant high horizontal is negative", hPolStat, 1'b0);

    // random duty patterns on both channels
    for (int it = 0; it < 12; it++) begin
      for (int c = 0; c < 2; c++) begin
        int p;
        int h;
        p = 9 + 2 * int'($urandom % 4);
        if ($urandom % 2 == 0) h = 1 + int'($urandom % (3 * p / 10));
        else h = p - 1 - int'($urandom % (3 * p / 10));
        setPattern(c, p, h);
      end
      waitCyc(3 * WCYC + 8);
      check("R3 random h polarity", hPolStat, expPol[0]);
      check("R3 random v polarity", vPolStat, expPol[1]);
      check("R5 active h present", hPresent, 1'b1);
      check("R5 active v present", vPresent, 1'b1);
      pinChecks(6, "R7/R8 random");
    end

    // R3 exact half: square wave with period 2*SDIV gives exactly half high
    setPattern(0, 2 * SDIV, SDIV);
    expPol[0] = 1'b0;
    setPattern(1, 11, 2);
    waitCyc(3 * WCYC + 8);
    check("R3 exact half is negative", hPolStat, 1'b0);
    check("R9 v positive alongside", vPolStat, 1'b1);

    // R4: switch H to positive pattern just after a window closes, value holds
    waitPhase(WCYC, 10);
    setPattern(0, 13, 2);
    waitCyc(50);
    check("R4 h polarity holds mid-window", hPolStat, 1'b0);
    waitCyc(3 * WCYC);
    check("R4 h polarity updates after windows", hPolStat, 1'b1);

    // R8: disabled outputs ignore sync toggling
    hOutEnN = 1'b1; vOutEnN = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #0.5;
      hGpioOut = 1'($urandom); vGpioOut = 1'($urandom);
      #0.5;
      check("R8 h pin is gpio", hSyncPin, hGpioOut);
      check("R8 v pin is gpio", vSyncPin, vGpioOut);
    end

    // R7 directed: constant inputs, both polarity selections
    run[0] = 0; run[1] = 0; cst[0] = 1'b1; cst[1] = 1'b0;
    expPol[0] = 1'b0; expPol[1] = 1'b1;
    waitCyc(2 * TOUT + 20);
    check("R6 h silent clears", hPresent, 1'b0);
    check("R6 v silent clears", vPresent, 1'b0);
    check("R3 const high h negative", hPolStat, 1'b0);
    check("R3 const low v positive", vPolStat, 1'b1);
    pinChecks(8, "R7 directed");

    done = 1;
    summary();
    $finish;
  end
endmodule